// File: doc/BRIEF.md
# Clock-Synchronous Serial Byte Receiver

This block takes in serial data one byte at a time on the edges of a transfer clock. The clock either comes in on a pin from the sending device or is generated here from the system clock. Software arms a transfer by writing a throwaway value to the transmit-buffer strobe while both the receive and transmit enables are high. Once armed, the block pulls its active-low ready line low so the sender may start clocking. If the block generates the clock itself, it starts toggling its clock output at the same point.

After eight sampling edges the assembled byte lands in a receive buffer. This raises a sticky completion flag and an interrupt request. Reading the buffer drops the completion flag. The sampling edge polarity, the bit order and an optional bit inversion are all configurable. In continuous mode a buffer read re-arms the receiver with no further dummy write. A byte that completes over an unread one sets an overrun flag.

Top module: `csync_rx`

## Requirements
- R1: A pulse on `tbuf_wr` while the receiver is idle arms it, but only once `rx_en` and `tx_en` are both 1. A write made without both enables is held and takes effect on the first edge where both are 1. Arming takes effect at the next clock edge.
- R2: With `cfg_rts_en`=1, `rts_oe`=1 and `rts_n` is 0 exactly while the receiver is armed. With `cfg_rts_en`=0, `rts_oe`=0 and `rts_n`=1, and reception still works.
- R3: With `cfg_msb_first`=0 the first received bit becomes bit 0 of `rbuf_data`. With `cfg_msb_first`=1 it becomes bit 7.
- R4: On the eighth sampling edge, `rbuf_data` loads the byte and `rx_done` and `rx_irq` go to 1. `rbuf_data` changes at no other time. `rx_irq` stays 1 until an `irq_clr` pulse.
- R5: With `cfg_ext_clk`=0, each half period of the generated clock lasts 1, 8 or 32 system clocks for `cfg_div_sel` = 0, 1 or 2 (3 behaves as 2). The clock starts with a falling half, samples on its rising transition, and stops at its idle (high) level once a byte is complete.
- R6: A `rbuf_rd` pulse clears `rx_done` at the next edge, unless a byte completes in that same cycle.
- R7: With `cfg_clk_inv`=0, sampling happens on the rising edge of the clock pin and the generated clock idles high. With `cfg_clk_inv`=1, sampling happens on the falling edge and the generated clock idles low.
- R8: With `cfg_data_inv`=1 every bit of the byte is inverted as it is written into `rbuf_data`.
- R9: With `cfg_cont_en`=1 the receiver disarms after a byte, so `rts_n` is 1 while the byte is unread. A `rbuf_rd` pulse then re-arms it at the next edge with no dummy write.
- R10: With `cfg_ext_clk`=1, `sclk_in` and `sdata_in` pass through a two-flop synchronizer. Edges arriving while the receiver is not armed are ignored and do not advance the bit count.
- R11: If a byte completes while `rx_done` is 1 and no read is made in that cycle, `rx_overrun` goes to 1 and the buffer takes the new byte. A read clears `rx_overrun`.
- R12: Dropping `rx_en` disarms the receiver at the next edge and discards any partly received bits. The next armed transfer starts from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext_clk | input | 1 | 1: transfer clock from `sclk_in`; 0: generated internally |
| cfg_div_sel | input | 2 | Internal clock divider select (1, 8, 32, 32) |
| cfg_clk_inv | input | 1 | Clock polarity select |
| cfg_msb_first | input | 1 | Bit order select |
| cfg_data_inv | input | 1 | Invert received data |
| cfg_cont_en | input | 1 | Continuous receive mode |
| cfg_rts_en | input | 1 | Enable the ready output |
| rx_en | input | 1 | Receive enable |
| tx_en | input | 1 | Transmit enable |
| tbuf_wr | input | 1 | Dummy transmit-buffer write strobe |
| rbuf_rd | input | 1 | Receive-buffer read strobe |
| irq_clr | input | 1 | Clear interrupt request |
| sclk_in | input | 1 | External transfer clock pin |
| sdata_in | input | 1 | Serial data pin |
| sclk_out | output | 1 | Generated transfer clock |
| sclk_oe | output | 1 | Drive enable for `sclk_out` |
| rts_n | output | 1 | Active-low ready-to-receive |
| rts_oe | output | 1 | Drive enable for `rts_n` |
| rbuf_data | output | 8 | Receive buffer |
| rx_done | output | 1 | Receive complete flag |
| rx_irq | output | 1 | Receive interrupt request |
| rx_overrun | output | 1 | Overrun flag |

## Verification
The bench builds the block with its defaults: an 8-bit word, divider ratios 1, 8 and 32, and a two-stage synchronizer. All three ratios are therefore reachable, and the bench can measure the exact generated half period at each. The ratio of 1 toggles the clock on every system edge, so data setup at the fastest rate is exercised. With the 32 ratio a whole byte still fits in about 500 cycles, which leaves room for dozens of random transfers that mix clock source, polarity, bit order and inversion.

// File: rtl/csync_rx_pkg.sv
package csync_rx_pkg;

  typedef enum logic [1:0] {
    DSEL_LO  = 2'd0,
    DSEL_MID = 2'd1,
    DSEL_HI  = 2'd2,
    DSEL_HI2 = 2'd3
  } div_sel_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/csync_rx_clkgen.sv
module csync_rx_clkgen
  import csync_rx_pkg::*;
#(
  parameter int DIV_A       = 1,
  parameter int DIV_B       = 8,
  parameter int DIV_C       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       ext_sel,
  input  logic       clk_inv,
  input  logic [1:0] div_sel,
  input  logic       sclk_pin,
  input  logic       sdata_pin,
  output logic       samp,
  output logic       samp_bit,
  output logic       sclk_drv
);

  localparam int DMAX = max3(DIV_A, DIV_B, DIV_C);
  localparam int CW   = $clog2(DMAX + 1);

  logic [SYNC_STAGES-1:0] ck_sync, dt_sync;
  logic                   ck_prev;
  logic [CW-1:0]          cnt, cnt_nx;
  logic                   sck, sck_nx;
  logic [CW-1:0]          div_m1;
  logic                   tick;
  logic                   n_cur, n_prev;
  logic                   ext_rise, int_rise;

  // divider terminal count
  always_comb begin
    case (div_sel_e'(div_sel))
      DSEL_LO:  div_m1 = CW'(DIV_A - 1);
      DSEL_MID: div_m1 = CW'(DIV_B - 1);
      default:  div_m1 = CW'(DIV_C - 1);
    endcase
  end

  assign tick = (cnt == div_m1);

  // internal clock next state
  always_comb begin
    cnt_nx = cnt;
    sck_nx = sck;
    if (!run || ext_sel) begin
      cnt_nx = '0;
      sck_nx = 1'b1;
    end else if (tick) begin
      cnt_nx = '0;
      sck_nx = ~sck;
    end else begin
      cnt_nx = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b1;
    end else begin
      cnt <= cnt_nx;
      sck <= sck_nx;
    end
  end

  // pin synchronizers, raw pin levels; polarity applied after
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_sync <= '1;
      dt_sync <= '0;
      ck_prev <= 1'b1;
    end else begin
      ck_sync <= {ck_sync[SYNC_STAGES-2:0], sclk_pin};
      dt_sync <= {dt_sync[SYNC_STAGES-2:0], sdata_pin};
      ck_prev <= ck_sync[SYNC_STAGES-1];
    end
  end

  assign n_cur    = ck_sync[SYNC_STAGES-1] ^ clk_inv;
  assign n_prev   = ck_prev ^ clk_inv;
  assign ext_rise = run & ext_sel & n_cur & ~n_prev;
  assign int_rise = run & ~ext_sel & tick & ~sck;

  assign samp     = ext_rise | int_rise;
  assign samp_bit = ext_sel ? dt_sync[SYNC_STAGES-1] : sdata_pin;
  assign sclk_drv = sck ^ clk_inv;

endmodule

// File: rtl/csync_rx_shift.sv
module csync_rx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         samp,
  input  logic         samp_bit,
  input  logic         msb_first,
  output logic         cmpl,
  output logic [W-1:0] word
);

  localparam int CNTW = $clog2(W);

  logic [W-1:0]    sreg;
  logic [CNTW-1:0] bcnt, bcnt_nx;
  logic [W-1:0]    sreg_nx;

  // new bit enters at bit 0 side for msb-first, at the top for lsb-first
  assign word = msb_first ? {sreg[W-2:0], samp_bit} : {samp_bit, sreg[W-1:1]};
  assign cmpl = samp & (bcnt == CNTW'(W - 1));

  always_comb begin
    bcnt_nx = bcnt;
    sreg_nx = sreg;
    if (clr) begin
      bcnt_nx = '0;
    end else if (samp) begin
      sreg_nx = word;
      bcnt_nx = cmpl ? '0 : bcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      sreg <= '0;
    end else begin
      bcnt <= bcnt_nx;
      sreg <= sreg_nx;
    end
  end

endmodule

// File: rtl/csync_rx_ctrl.sv
module csync_rx_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_en,
  input  logic         tx_en,
  input  logic         tbuf_wr,
  input  logic         rbuf_rd,
  input  logic         irq_clr,
  input  logic         cont_en,
  input  logic         rts_en,
  input  logic         data_inv,
  input  logic         cmpl,
  input  logic [W-1:0] word,
  output logic         armed,
  output logic         rts_n,
  output logic         rts_oe,
  output logic [W-1:0] rbuf,
  output logic         done,
  output logic         irq,
  output logic         ovr
);

  logic         pend, pend_nx;
  logic         hold, hold_nx;
  logic         armed_nx, done_nx, irq_nx, ovr_nx;
  logic [W-1:0] rbuf_nx;
  logic         both_en, arm_req, rearm_req;

  assign both_en   = rx_en & tx_en;
  assign arm_req   = ~armed & (pend | tbuf_wr) & both_en;
  assign rearm_req = ~armed & hold & cont_en & rbuf_rd & both_en;

  always_comb begin
    pend_nx  = pend;
    hold_nx  = hold;
    armed_nx = armed;
    done_nx  = done;
    irq_nx   = irq;
    ovr_nx   = ovr;
    rbuf_nx  = rbuf;

    if (tbuf_wr && !armed) pend_nx = 1'b1;
    if (arm_req)           pend_nx = 1'b0;

    if (!both_en)                    armed_nx = 1'b0;
    else if (cmpl)                   armed_nx = 1'b0;
    else if (arm_req || rearm_req)   armed_nx = 1'b1;

    if (!cont_en || rbuf_rd) hold_nx = 1'b0;
    if (cmpl && cont_en)     hold_nx = 1'b1;

    if (cmpl) begin
      rbuf_nx = word ^ {W{data_inv}};
      done_nx = 1'b1;
      irq_nx  = 1'b1;
      if (done && !rbuf_rd) ovr_nx = 1'b1;
      else if (rbuf_rd)     ovr_nx = 1'b0;
    end else begin
      if (rbuf_rd) begin
        done_nx = 1'b0;
        ovr_nx  = 1'b0;
      end
      if (irq_clr) irq_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      hold  <= 1'b0;
      armed <= 1'b0;
      done  <= 1'b0;
      irq   <= 1'b0;
      ovr   <= 1'b0;
      rbuf  <= '0;
    end else begin
      pend  <= pend_nx;
      hold  <= hold_nx;
      armed <= armed_nx;
      done  <= done_nx;
      irq   <= irq_nx;
      ovr   <= ovr_nx;
      rbuf  <= rbuf_nx;
    end
  end

  assign rts_oe = rts_en;
  assign rts_n  = rts_en ? ~armed : 1'b1;

endmodule

// File: rtl/csync_rx.sv
module csync_rx
  import csync_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_A       = 1,
  parameter int DIV_B       = 8,
  parameter int DIV_C       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ext_clk,
  input  logic [1:0]        cfg_div_sel,
  input  logic              cfg_clk_inv,
  input  logic              cfg_msb_first,
  input  logic              cfg_data_inv,
  input  logic              cfg_cont_en,
  input  logic              cfg_rts_en,
  input  logic              rx_en,
  input  logic              tx_en,
  input  logic              tbuf_wr,
  input  logic              rbuf_rd,
  input  logic              irq_clr,
  input  logic              sclk_in,
  input  logic              sdata_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  output logic              rts_n,
  output logic              rts_oe,
  output logic [DATA_W-1:0] rbuf_data,
  output logic              rx_done,
  output logic              rx_irq,
  output logic              rx_overrun
);

  logic              armed;
  logic              samp, samp_bit;
  logic              cmpl;
  logic [DATA_W-1:0] word;

  csync_rx_clkgen #(
    .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .SYNC_STAGES(SYNC_STAGES)
  ) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (armed),
    .ext_sel  (cfg_ext_clk),
    .clk_inv  (cfg_clk_inv),
    .div_sel  (cfg_div_sel),
    .sclk_pin (sclk_in),
    .sdata_pin(sdata_in),
    .samp     (samp),
    .samp_bit (samp_bit),
    .sclk_drv (sclk_out)
  );

  csync_rx_shift #(.W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (~armed),
    .samp     (samp),
    .samp_bit (samp_bit),
    .msb_first(cfg_msb_first),
    .cmpl     (cmpl),
    .word     (word)
  );

  csync_rx_ctrl #(.W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_en   (rx_en),
    .tx_en   (tx_en),
    .tbuf_wr (tbuf_wr),
    .rbuf_rd (rbuf_rd),
    .irq_clr (irq_clr),
    .cont_en (cfg_cont_en),
    .rts_en  (cfg_rts_en),
    .data_inv(cfg_data_inv),
    .cmpl    (cmpl),
    .word    (word),
    .armed   (armed),
    .rts_n   (rts_n),
    .rts_oe  (rts_oe),
    .rbuf    (rbuf_data),
    .done    (rx_done),
    .irq     (rx_irq),
    .ovr     (rx_overrun)
  );

  assign sclk_oe = ~cfg_ext_clk;

endmodule

// File: rtl/csync_rx_chk.sv
module csync_rx_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         armed,
  input logic         cmpl,
  input logic         rbuf_rd,
  input logic         cfg_ext_clk,
  input logic         cfg_clk_inv,
  input logic         sclk_out,
  input logic         rts_n,
  input logic         rts_oe,
  input logic [W-1:0] rbuf_data,
  input logic         rx_done,
  input logic         rx_irq,
  input logic         rx_overrun
);

  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> rx_irq); // R4

  AST_BUF_ONLY_ON_CMPL: assert property (@(posedge clk) disable iff (!rst_n)
    !cmpl |=> $stable(rbuf_data)); // R4

  AST_READ_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rbuf_rd && !cmpl) |=> !rx_done); // R6

  AST_RTS_LOW_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_n |-> (rts_oe && armed)); // R2

  AST_CLK_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ext_clk && !armed && $past(!armed)) |-> ((sclk_out ^ cfg_clk_inv) == 1'b1)); // R5

  AST_DISARM_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl |=> !armed); // R9

  AST_OVERRUN_ON_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl && rx_done && !rbuf_rd) |=> rx_overrun); // R11

endmodule

bind csync_rx csync_rx_chk #(.W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .armed      (armed),
  .cmpl       (cmpl),
  .rbuf_rd    (rbuf_rd),
  .cfg_ext_clk(cfg_ext_clk),
  .cfg_clk_inv(cfg_clk_inv),
  .sclk_out   (sclk_out),
  .rts_n      (rts_n),
  .rts_oe     (rts_oe),
  .rbuf_data  (rbuf_data),
  .rx_done    (rx_done),
  .rx_irq     (rx_irq),
  .rx_overrun (rx_overrun)
);

// File: tb/test_csync_rx.sv
`timescale 1ns/1ps
module test_csync_rx;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic       c_ext, c_inv, c_msb, c_dinv, c_cont, c_rts;
  logic [1:0] c_div;
  logic       rx_en, tx_en, tbuf_wr, rbuf_rd, irq_clr;
  logic       ext_norm, sdata_in;
  wire        sclk_in = ext_norm ^ c_inv;
  logic       sclk_out, sclk_oe, rts_n, rts_oe;
  logic [7:0] rbuf_data;
  logic       rx_done, rx_irq, rx_overrun;
  wire        norm_int = sclk_out ^ c_inv;

  int     n_vec = 0;
  int     n_bad = 0;
  longint t_fall, t_rise;

  csync_rx i_csync_rx (
    .clk(clk), .rst_n(rst_n),
    .cfg_ext_clk(c_ext), .cfg_div_sel(c_div), .cfg_clk_inv(c_inv),
    .cfg_msb_first(c_msb), .cfg_data_inv(c_dinv), .cfg_cont_en(c_cont),
    .cfg_rts_en(c_rts), .rx_en(rx_en), .tx_en(tx_en), .tbuf_wr(tbuf_wr),
    .rbuf_rd(rbuf_rd), .irq_clr(irq_clr), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .rts_n(rts_n), .rts_oe(rts_oe),
    .rbuf_data(rbuf_data), .rx_done(rx_done), .rx_irq(rx_irq), .rx_overrun(rx_overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] w, input logic msb, input logic inv);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = msb ? w[7-i] : w[i];
    return inv ? ~r : r;
  endfunction

  function automatic int div_of(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 8 : 32;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm();
    tbuf_wr = 1'b1; tick(1); tbuf_wr = 1'b0;
  endtask

  task automatic rd();
    rbuf_rd = 1'b1; tick(1); rbuf_rd = 1'b0;
  endtask

  task automatic clr_irq();
    irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
  endtask

  // sender on the generated clock: change data after each falling half
  task automatic send_int(input logic [7:0] w);
    for (int i = 0; i < 8; i++) begin
      @(negedge norm_int);
      if (i == 0) t_fall = $time;
      #2 sdata_in = w[i];
      @(posedge norm_int);
      if (i == 0) t_rise = $time;
    end
    @(negedge clk);
  endtask

  // sender that produces the clock itself
  task automatic send_ext(input logic [7:0] w, input int nb);
    for (int i = 0; i < nb; i++) begin
      ext_norm = 1'b0; sdata_in = w[i];
      tick(4);
      ext_norm = 1'b1;
      tick(4);
    end
    tick(1);
  endtask

  task automatic send(input logic [7:0] w);
    if (c_ext) send_ext(w, 8);
    else       send_int(w);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] w;
    int d;
    rst_n = 1'b0; c_ext = 0; c_inv = 0; c_msb = 0; c_dinv = 0; c_cont = 0; c_rts = 1;
    c_div = 0; rx_en = 1; tx_en = 0; tbuf_wr = 0; rbuf_rd = 0; irq_clr = 0;
    ext_norm = 1; sdata_in = 0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // reset state
    chk("R2 reset rts_n", rts_n, 1);
    chk("R2 reset rts_oe", rts_oe, 1);
    chk("R4 reset done", rx_done, 0);
    chk("R4 reset irq", rx_irq, 0);
    chk("R11 reset overrun", rx_overrun, 0);
    chk("R4 reset buffer", rbuf_data, 0);
    chk("R5 reset clock idle", sclk_out, 1);

    // R1: write held until both enables
    arm();
    chk("R1 no tx enable", rts_n, 1);
    tick(3);
    chk("R1 still idle", rts_n, 1);
    tx_en = 1'b1;
    tick(1);
    chk("R1 held write arms", rts_n, 0);
    send_int(8'hA5);
    chk("R3 lsb first", rbuf_data, 8'hA5);
    rd(); clr_irq();

    // R2: ready output disabled
    c_rts = 0;
    arm();
    chk("R2 disabled oe", rts_oe, 0);
    chk("R2 disabled level", rts_n, 1);
    send_int(8'h3C);
    chk("R2 receives without ready", rbuf_data, 8'h3C);
    rd(); clr_irq();
    c_rts = 1;

    // R8 with msb first
    c_msb = 1; c_dinv = 1;
    arm(); send_int(8'h01);
    chk("R8 inverted msb-first", rbuf_data, 8'h7F);
    rd(); clr_irq();
    c_msb = 0; c_dinv = 0;

    // R7: idle pin level with inverted polarity
    c_inv = 1; tick(2);
    chk("R7 idle low", sclk_out, 0);
    c_inv = 0; tick(2);

    // R10: edges while idle ignored
    c_ext = 1; tick(3);
    for (int i = 0; i < 5; i++) begin
      ext_norm = 0; sdata_in = 1; tick(4); ext_norm = 1; tick(4);
    end
    chk("R10 idle edges ignored", rx_done, 0);
    arm(); send_ext(8'hC6, 8);
    chk("R10 external byte", rbuf_data, 8'hC6);
    rd(); clr_irq();

    // R12: abort discards partial bits
    arm(); send_ext(8'hFF, 3);
    rx_en = 0; tick(1);
    chk("R12 disarmed", rts_n, 1);
    rx_en = 1; tick(2);
    chk("R12 stays idle", rts_n, 1);
    arm(); send_ext(8'h12, 8);
    chk("R12 partial discarded", rbuf_data, 8'h12);
    rd(); clr_irq();

    // R11: overrun
    c_ext = 0; tick(2);
    arm(); send_int(8'h55);
    chk("R11 no overrun yet", rx_overrun, 0);
    arm(); send_int(8'hAA);
    chk("R11 overrun set", rx_overrun, 1);
    chk("R11 buffer overwritten", rbuf_data, 8'hAA);
    rd();
    chk("R11 overrun cleared", rx_overrun, 0);
    chk("R6 done cleared", rx_done, 0);
    chk("R4 irq held after read", rx_irq, 1);
    clr_irq();
    chk("R4 irq cleared", rx_irq, 0);

    // R9: continuous mode
    c_cont = 1; c_div = 1;
    arm(); send_int(8'h6B);
    chk("R9 ready high while unread", rts_n, 1);
    tick(5);
    chk("R9 still high", rts_n, 1);
    chk("R5 stopped idle", sclk_out, 1);
    rd();
    chk("R9 read rearms", rts_n, 0);
    chk("R9 first byte", rbuf_data, 8'h6B);
    send_int(8'h9E);
    chk("R9 second byte", rbuf_data, 8'h9E);
    rd();
    rx_en = 0; tick(1); rx_en = 1;
    c_cont = 0; tick(1);
    clr_irq();

    // random mix
    for (int it = 0; it < 40; it++) begin
      c_ext = 1'($urandom % 2); c_div = 2'($urandom % 4); c_inv = 1'($urandom % 2);
      c_msb = 1'($urandom % 2); c_dinv = 1'($urandom % 2);
      w = 8'($urandom);
      ext_norm = 1;
      tick(3);
      arm();
      chk("R1 random arm", rts_n, 0);
      send(w);
      chk("R3 R8 random data", rbuf_data, exp_byte(w, c_msb, c_dinv));
      chk("R4 random done", rx_done, 1);
      chk("R4 random irq", rx_irq, 1);
      if (!c_ext) begin
        d = div_of(c_div);
        chk("R5 half period", 32'((t_rise - t_fall) / 20), d);
        tick(2 * d);
        chk("R7 idle level", sclk_out, !c_inv);
      end
      chk("R2 ready released", rts_n, 1);
      rd();
      chk("R6 random read", rx_done, 0);
      clr_irq();
    end

    summary();
    $finish;
  end

endmodule